// File: doc/BRIEF.md
# Cross-Coupled Four-Voice Tone Mixer

This block produces the stereo level of a small sound generator built from three programmable tone voices and one noise voice. All four voices advance together on a base tick enable. Each tone voice divides the tick by a 12-bit code and either toggles or samples one of three external pseudo-random bits. Each voice can be reset to zero by a falling edge of a neighbour (high-pass) or XNORed with another neighbour (ring modulation). The noise voice takes its bit from an external noise generator and may additionally hold that bit until the third tone voice falls (low-pass). The external pseudo-random bits and the noise generator are outside this block and arrive as input pins.

A host programs sixteen byte-wide registers through a plain write strobe. The mixer adds the per-voice six-bit volumes of the voices that are high, separately for each side. Either side can instead be switched to a direct-level mode. A tape echo adds a fixed level to both sides. No data stream crosses the block's edge, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. The mixed levels are combinational functions of registered state.

Top module: `xc_tone_mixer`

## Requirements
- R1: A synchronous reset clears every register, counter and voice output to zero and leaves all three tone voices running (not held). With tape echo off, both outputs read 0 after reset.
- R2: A running tone voice with code N and square-wave source changes its output only on ticks. The first tick after its counter reaches 0 reloads N and inverts the output. The result is an output period of 2*(N+1) ticks, and the first inversion happens on the first tick after reset. Voice outputs never change in a cycle without a tick.
- R3: Bits 5:4 of a tone voice's odd register (addresses 1, 3, 5) select what is loaded at underflow: 00 square toggle, 01 poly_bits[0], 10 poly_bits[1], 11 poly_bits[2]. Bits 3:0 of that register are code bits 11:8, and the even register below it holds code bits 7:0.
- R4: With bit 6 of its odd register set, tone voice k has its oscillator bit cleared on any tick in which voice k+1 falls from 1 to 0. The pairings are 0 by 1, 1 by 2 and 2 by 3. Bit 6 of register 6 does the same for the noise voice, with voice 0 as the partner.
- R5: With bit 7 of its mode register set, a voice's output is its oscillator bit XNOR a partner's output. The partners are 0 with 2, 1 with 3, 2 with 0, and noise (register 6 bit 7) with 1.
- R6: With register 6 bit 5 clear, the noise voice takes noise_bit on every tick. With it set, the noise voice keeps its value and loads noise_bit only on a tick that follows a tick in which voice 2 fell.
- R7: Within a tick the voices are evaluated noise first, then 2, 1, 0. A partner evaluated earlier in the same tick contributes its new output or edge. A partner evaluated later contributes its output, or its falling edge, from the previous tick.
- R8: Register 7 bits 2:0 hold tone voices 0 to 2. While a voice is held, its oscillator bit is 0 and its counter is frozen. Clearing the bit reloads the counter with the current code, and the voice resumes from there.
- R9: Registers 8 to 11 are the left volumes and 12 to 15 the right volumes of voices 0 to 3 (low six bits used). On a normal side, the output is the sum of the volumes of the voices whose output is 1.
- R10: Register 7 bit 3 (left) and bit 4 (right) select direct-level mode. A side in that mode outputs voice 0's volume for that side times 4, whatever the voice outputs are.
- R11: When tape_fb_en and tape_in are both 1, 63 is added to both outputs in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick enable; voices advance on cycles where it is 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| poly_bits | input | 3 | External pseudo-random bits selectable by the tone voices |
| noise_bit | input | 1 | External noise generator bit |
| tape_fb_en | input | 1 | Tape echo enable |
| tape_in | input | 1 | Tape input level |
| left | output | VOL_W+3 | Left mixed level |
| right | output | VOL_W+3 | Right mixed level |

## Verification
The hardest situation to reach from the pins is the timing of the cross-voice edges. One case is a partner's falling edge that must act in the same tick; another is one that acts a tick late because that partner is evaluated after its victim. The stimulus sets the partner's code to 0, so it inverts on every tick and its falling edges land on predictable ticks. The victim gets a large code, so it holds a 1 that only the edge can clear. The output is then sampled after each tick, so a one-tick slip in the evaluation order changes the level seen at the pins.

// File: rtl/xc_mix_pkg.sv
package xc_mix_pkg;
  localparam int NUM_TONE = 3;
  localparam int NUM_CH   = NUM_TONE + 1;
  localparam int CODE_LO  = 8;
  localparam int CODE_HI  = 4;
  localparam int FREQ_W   = CODE_LO + CODE_HI;
  localparam int NOISE_IX = NUM_CH - 1;

  typedef enum logic [1:0] {
    SRC_SQUARE = 2'b00,
    SRC_POLY_A = 2'b01,
    SRC_POLY_B = 2'b10,
    SRC_POLY_C = 2'b11
  } src_sel_e;

  localparam logic [3:0] ADDR_NOISE = 4'h6;
  localparam logic [3:0] ADDR_SCTL  = 4'h7;
endpackage

// File: rtl/xc_tone_voice.sv
module xc_tone_voice
  import xc_mix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [FREQ_W-1:0] code,
  input  src_sel_e          src,
  input  logic              hp_en,
  input  logic              rm_en,
  input  logic [2:0]        poly_bits,
  input  logic              hold_q,
  input  logic              hold_wr,
  input  logic              hold_new,
  input  logic              hp_fall,
  input  logic              rm_ref,
  output logic              osc_q,
  output logic              out_q,
  output logic              fall_q,
  output logic              out_nx,
  output logic              fall_nx
);
  logic [FREQ_W-1:0] cnt_q, cnt_nx;
  logic              osc_nx, load_bit;

  always_comb begin
    case (src)
      SRC_POLY_A: load_bit = poly_bits[0];
      SRC_POLY_B: load_bit = poly_bits[1];
      SRC_POLY_C: load_bit = poly_bits[2];
      default:    load_bit = ~osc_q;
    endcase
  end

  always_comb begin
    cnt_nx = cnt_q;
    osc_nx = osc_q;
    if (!hold_q) begin
      if (cnt_q == '0) begin
        cnt_nx = code;
        osc_nx = load_bit;
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
    if (hp_en && hp_fall) osc_nx = 1'b0;
    out_nx  = rm_en ? ~(osc_nx ^ rm_ref) : osc_nx;
    fall_nx = out_q & ~out_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      osc_q  <= 1'b0;
      out_q  <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q  <= cnt_nx;
        osc_q  <= osc_nx;
        out_q  <= out_nx;
        fall_q <= fall_nx;
      end
      if (hold_wr) begin
        if (hold_new)    osc_q <= 1'b0;
        else if (hold_q) cnt_q <= code;
      end
    end
  end
endmodule

// File: rtl/xc_noise_voice.sv
module xc_noise_voice (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic noise_bit,
  input  logic lp_en,
  input  logic hp_en,
  input  logic rm_en,
  input  logic lp_fall,
  input  logic hp_fall,
  input  logic rm_ref,
  output logic out_q,
  output logic fall_q,
  output logic out_nx,
  output logic fall_nx
);
  logic held_q, held_nx;

  always_comb begin
    held_nx = lp_en ? (lp_fall ? noise_bit : held_q) : noise_bit;
    if (hp_en && hp_fall) held_nx = 1'b0;
    out_nx  = rm_en ? ~(held_nx ^ rm_ref) : held_nx;
    fall_nx = out_q & ~out_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      out_q  <= 1'b0;
      fall_q <= 1'b0;
    end else if (tick) begin
      held_q <= held_nx;
      out_q  <= out_nx;
      fall_q <= fall_nx;
    end
  end
endmodule

// File: rtl/xc_stereo_sum.sv
module xc_stereo_sum #(
  parameter int VOL_W  = 6,
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] ch_on,
  input  logic [VOL_W-1:0]  vol_l [NUM_CH],
  input  logic [VOL_W-1:0]  vol_r [NUM_CH],
  input  logic              direct_l,
  input  logic              direct_r,
  input  logic              echo,
  output logic [VOL_W+2:0]  left,
  output logic [VOL_W+2:0]  right
);
  localparam int OUT_W = VOL_W + 3;
  logic [OUT_W-1:0] base, sum_l, sum_r;

  always_comb begin
    base  = echo ? OUT_W'({VOL_W{1'b1}}) : '0;
    sum_l = base;
    sum_r = base;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_on[c]) begin
        sum_l = sum_l + OUT_W'(vol_l[c]);
        sum_r = sum_r + OUT_W'(vol_r[c]);
      end
    end
    left  = direct_l ? base + OUT_W'({vol_l[0], 2'b00}) : sum_l;
    right = direct_r ? base + OUT_W'({vol_r[0], 2'b00}) : sum_r;
  end
endmodule

// File: rtl/xc_tone_mixer.sv
module xc_tone_mixer
  import xc_mix_pkg::*;
#(
  parameter int VOL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       poly_bits,
  input  logic             noise_bit,
  input  logic             tape_fb_en,
  input  logic             tape_in,
  output logic [VOL_W+2:0] left,
  output logic [VOL_W+2:0] right
);
  logic [FREQ_W-1:0]   code   [NUM_TONE];
  src_sel_e            src    [NUM_TONE];
  logic [NUM_CH-1:0]   hp_en, rm_en;
  logic                lp_en, dac_l, dac_r;
  logic [NUM_TONE-1:0] sync_q;
  logic [VOL_W-1:0]    vol_l  [NUM_CH];
  logic [VOL_W-1:0]    vol_r  [NUM_CH];
  logic                sctl_wr;

  logic out_q [NUM_CH];
  logic out_nx [NUM_CH];
  logic fall_q [NUM_CH];
  logic fall_nx [NUM_CH];
  logic [NUM_CH-1:0]   ch_out_vec;
  logic [NUM_TONE-1:0] osc_vec;

  assign sctl_wr = wr_en && (wr_addr == ADDR_SCTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_TONE; c++) begin
        code[c] <= '0;
        src[c]  <= SRC_SQUARE;
      end
      for (int c = 0; c < NUM_CH; c++) begin
        vol_l[c] <= '0;
        vol_r[c] <= '0;
      end
      hp_en  <= '0;
      rm_en  <= '0;
      lp_en  <= 1'b0;
      dac_l  <= 1'b0;
      dac_r  <= 1'b0;
      sync_q <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_TONE; c++) begin
        if (wr_addr == 4'(2 * c)) code[c][CODE_LO-1:0] <= wr_data;
        if (wr_addr == 4'(2 * c + 1)) begin
          code[c][FREQ_W-1:CODE_LO] <= wr_data[CODE_HI-1:0];
          src[c]   <= src_sel_e'(wr_data[5:4]);
          hp_en[c] <= wr_data[6];
          rm_en[c] <= wr_data[7];
        end
      end
      if (wr_addr == ADDR_NOISE) begin
        lp_en           <= wr_data[5];
        hp_en[NOISE_IX] <= wr_data[6];
        rm_en[NOISE_IX] <= wr_data[7];
      end
      if (wr_addr == ADDR_SCTL) begin
        sync_q <= wr_data[NUM_TONE-1:0];
        dac_l  <= wr_data[3];
        dac_r  <= wr_data[4];
      end
      if (wr_addr[3]) begin
        if (wr_addr[2]) vol_r[wr_addr[1:0]] <= wr_data[VOL_W-1:0];
        else            vol_l[wr_addr[1:0]] <= wr_data[VOL_W-1:0];
      end
    end
  end

  xc_noise_voice u_noise (
    .clk(clk), .rst(rst), .tick(tick), .noise_bit(noise_bit),
    .lp_en(lp_en), .hp_en(hp_en[NOISE_IX]), .rm_en(rm_en[NOISE_IX]),
    .lp_fall(fall_q[2]), .hp_fall(fall_q[0]), .rm_ref(out_q[1]),
    .out_q(out_q[NOISE_IX]), .fall_q(fall_q[NOISE_IX]),
    .out_nx(out_nx[NOISE_IX]), .fall_nx(fall_nx[NOISE_IX])
  );

  for (genvar g = 0; g < NUM_TONE; g++) begin : g_tone
    localparam int HP_P = g + 1;
    localparam int RM_P = (g + 2) % NUM_CH;
    logic rm_ref;
    if (RM_P > g) begin : g_rm_new
      assign rm_ref = out_nx[RM_P];
    end else begin : g_rm_old
      assign rm_ref = out_q[RM_P];
    end
    xc_tone_voice u_voice (
      .clk(clk), .rst(rst), .tick(tick),
      .code(code[g]), .src(src[g]), .hp_en(hp_en[g]), .rm_en(rm_en[g]),
      .poly_bits(poly_bits), .hold_q(sync_q[g]),
      .hold_wr(sctl_wr), .hold_new(wr_data[g]),
      .hp_fall(fall_nx[HP_P]), .rm_ref(rm_ref),
      .osc_q(osc_vec[g]), .out_q(out_q[g]), .fall_q(fall_q[g]),
      .out_nx(out_nx[g]), .fall_nx(fall_nx[g])
    );
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) ch_out_vec[c] = out_q[c];
  end

  xc_stereo_sum #(.VOL_W(VOL_W), .NUM_CH(NUM_CH)) u_sum (
    .ch_on(ch_out_vec), .vol_l(vol_l), .vol_r(vol_r),
    .direct_l(dac_l), .direct_r(dac_r), .echo(tape_fb_en & tape_in),
    .left(left), .right(right)
  );
endmodule

// File: rtl/xc_tone_mixer_chk.sv
module xc_tone_mixer_chk #(
  parameter int VOL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [3:0]       ch_out,
  input logic [2:0]       sync_q,
  input logic [2:0]       osc_q,
  input logic             tape_fb_en,
  input logic             tape_in,
  input logic             dac_l,
  input logic [VOL_W-1:0] vol_l0,
  input logic [VOL_W+2:0] left,
  input logic [VOL_W+2:0] right
);
  // R1: reset clears voice outputs and releases every hold
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ch_out == '0 && sync_q == '0));

  // R2: voice outputs move only on ticks
  a_r2_no_tick_stable: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ch_out));

  // R8: a voice held across cycles keeps a zero oscillator bit
  a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
    ((sync_q & $past(sync_q) & osc_q) == '0));

  // R10: direct-level left side without echo equals four times voice 0 volume
  a_r10_direct_left: assert property (@(posedge clk) disable iff (rst)
    (dac_l && !(tape_fb_en && tape_in)) |-> (left == (VOL_W+3)'({vol_l0, 2'b00})));

  // R11: tape echo lifts both sides by at least 63
  a_r11_echo_floor: assert property (@(posedge clk) disable iff (rst)
    (tape_fb_en && tape_in) |-> (left >= 63 && right >= 63));
endmodule

bind xc_tone_mixer xc_tone_mixer_chk #(.VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ch_out(ch_out_vec), .sync_q(sync_q),
  .osc_q(osc_vec), .tape_fb_en(tape_fb_en), .tape_in(tape_in),
  .dac_l(dac_l), .vol_l0(vol_l[0]), .left(left), .right(right)
);

// File: tb/tb_xc_tone_mixer.sv
module tb_xc_tone_mixer;
  localparam int VOL_W = 6;
  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] poly_bits = '0;
  logic noise_bit = 1'b0, tape_fb_en = 1'b0, tape_in = 1'b0;
  logic [VOL_W+2:0] left, right;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  xc_tone_mixer #(.VOL_W(VOL_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .poly_bits(poly_bits), .noise_bit(noise_bit),
    .tape_fb_en(tape_fb_en), .tape_in(tape_in), .left(left), .right(right)
  );

  // entry: direct_l, direct_r, echo_en, echo_in, expected left, expected right
  localparam logic [21:0] MIX_VEC [8] = '{
    {4'b0000, 9'd100, 9'd81},
    {4'b1000, 9'd40,  9'd81},
    {4'b0100, 9'd100, 9'd20},
    {4'b1100, 9'd40,  9'd20},
    {4'b0010, 9'd100, 9'd81},
    {4'b0001, 9'd100, 9'd81},
    {4'b0011, 9'd163, 9'd144},
    {4'b1111, 9'd103, 9'd83}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; poly_bits = '0; noise_bit = 1'b0;
    tape_fb_en = 1'b0; tape_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int exp_seq [7] = '{1, 1, 1, 0, 0, 0, 1};
    do_reset();
    chk("R1 reset left", int'(left), 0);
    chk("R1 reset right", int'(right), 0);

    // R9 R10 R11: all four voices high, walk the mixing table
    for (int c = 0; c < 3; c++) begin
      wr(4'(2 * c), 8'hFF);
      wr(4'(2 * c + 1), 8'h0F);
    end
    wr(4'h8, 8'd10); wr(4'h9, 8'd20); wr(4'hA, 8'd30); wr(4'hB, 8'd40);
    wr(4'hC, 8'd5);  wr(4'hD, 8'd6);  wr(4'hE, 8'd7);  wr(4'hF, 8'd63);
    noise_bit = 1'b1;
    step();
    for (int i = 0; i < 8; i++) begin
      wr(4'h7, {3'b000, MIX_VEC[i][20], MIX_VEC[i][21], 3'b000});
      tape_fb_en = MIX_VEC[i][19];
      tape_in    = MIX_VEC[i][18];
      @(negedge clk);
      chk($sformatf("R9/R10/R11 table %0d left", i), int'(left), int'(MIX_VEC[i][17:9]));
      chk($sformatf("R9/R10/R11 table %0d right", i), int'(right), int'(MIX_VEC[i][8:0]));
    end

    // R2: period of a square voice with code 2, first flip on first tick
    do_reset();
    wr(4'h0, 8'd2); wr(4'h1, 8'h00); wr(4'h8, 8'd1);
    for (int i = 0; i < 7; i++) begin
      step();
      chk($sformatf("R2 tick %0d", i + 1), int'(left), exp_seq[i]);
      if (i == 0) begin
        repeat (4) @(negedge clk);
        chk("R2 no tick no change", int'(left), 1);
      end
    end

    // R3: source selection at underflow
    do_reset();
    wr(4'h1, 8'h10); wr(4'h8, 8'd1);
    poly_bits = 3'b001; step(); chk("R3 src01 high", int'(left), 1);
    poly_bits = 3'b000; step(); chk("R3 src01 low", int'(left), 0);
    wr(4'h1, 8'h20);
    poly_bits = 3'b010; step(); chk("R3 src10 high", int'(left), 1);
    wr(4'h1, 8'h30);
    poly_bits = 3'b011; step(); chk("R3 src11 low", int'(left), 0);

    // R8: hold and release with reload
    do_reset();
    wr(4'h8, 8'd1);
    step(); chk("R8 running", int'(left), 1);
    wr(4'h7, 8'h01);
    step(); chk("R8 held zero", int'(left), 0);
    step(); chk("R8 held stays", int'(left), 0);
    wr(4'h0, 8'd3);
    wr(4'h7, 8'h00);
    step(); step(); step();
    chk("R8 reload not yet", int'(left), 0);
    step(); chk("R8 resumes after code+1", int'(left), 1);

    // R5: ring modulation, voices held so oscillators are 0
    do_reset();
    wr(4'h7, 8'h07); wr(4'h1, 8'h80); wr(4'h6, 8'h80);
    wr(4'h8, 8'd1); wr(4'hA, 8'd4); wr(4'hB, 8'd8);
    step(); chk("R5 xnor zeros", int'(left), 9);
    noise_bit = 1'b1;
    step(); chk("R5 noise xnor one", int'(left), 1);

    // R4 R7: voice 0 cleared by same-tick fall of voice 1
    do_reset();
    wr(4'h0, 8'hFF); wr(4'h1, 8'h4F); wr(4'h8, 8'd1);
    step(); chk("R4 victim high", int'(left), 1);
    step(); chk("R4/R7 same-tick clear", int'(left), 0);
    step(); chk("R4 stays cleared", int'(left), 0);

    // R6 R7: noise low-pass uses previous-tick fall of voice 2
    do_reset();
    wr(4'h6, 8'h20); wr(4'hB, 8'd8);
    noise_bit = 1'b1;
    step(); chk("R6 hold tick1", int'(left), 0);
    step(); chk("R6/R7 hold tick2", int'(left), 0);
    step(); chk("R6/R7 load after fall", int'(left), 8);
    noise_bit = 1'b0;
    step(); chk("R6 hold between falls", int'(left), 8);
    step(); chk("R6 load next fall", int'(left), 0);
    wr(4'h6, 8'h00);
    noise_bit = 1'b1;
    step(); chk("R6 follow without lowpass", int'(left), 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule